// File: doc/BRIEF.md
# SDRAM Read-to-Write Turnaround Scheduler

This block sequences column commands for a single-data-rate SDRAM controller whose rows are already open. Requests arrive one at a time through a valid/ready handshake. Each request is either a read, which carries a tag, or a write, which carries a 16-bit word. The block turns every request into one READ or WRITE command with bank and column fields, and fills all other cycles with NOP. The burst length is one word, so a READ can be issued on every clock to any bank and column, which gives a continuous stream of returned data. Each returned word comes back with its tag, in issue order, exactly CAS-latency cycles after its command.

When a write follows reads, the block picks the earliest slot in which the controller's data drivers cannot collide with data the memory is still driving. There are two ways to clear the bus. The first is to wait until the last read word has gone by. The second is to truncate the read stream. To truncate, the block raises the DQM mask for at least two cycles ahead of the WRITE and keeps it high on the cycle just before the WRITE. Reads whose data falls under the mask are dropped and return nothing. A configuration bit adds one idle bus cycle between the last read word and the write, for boards where the controller's drivers can turn on before the memory's drivers turn off. While a turnaround is being enforced, the handshake holds off further requests.

Top module: `sdram_rtw_sched`

## Requirements
- R1: While reset is held low, and in the first cycle after it is released with no request, cmd_code is NOP (2'b00), dqm_out and dq_oe are 0, rd_valid is 0 and req_ready is 1.
- R2: A read request accepted on a clock edge (req_valid and req_ready high, req_write low) appears in the next cycle as a READ (cmd_code 2'b01) with its bank and column on cmd_bank/cmd_col. Consecutive read requests are accepted on consecutive edges.
- R3: For a READ shown in cycle c, rd_valid is high in cycle c+2 when cfg_cas3 is 0, and in cycle c+3 when cfg_cas3 is 1. In that cycle rd_tag is the request's tag and rd_data equals dq_rdata. Tags return in issue order.
- R4: A write request accepted when no read data is outstanding appears in the next cycle as a WRITE (cmd_code 2'b10), with dq_oe high and dq_wdata equal to the request data. dq_oe is high in exactly the cycles in which cmd_code is WRITE.
- R5: When waiting for the read data to drain is no slower than truncating, the WRITE is placed in the first cycle after the last read word, plus one cycle when cfg_gap is 1. In that case dqm_out stays 0.
- R6: When truncating is faster (only possible with CAS latency 3 and a READ in the cycle of the write's acceptance), dqm_out is high from the cycle after acceptance up to and including the cycle before the WRITE. That is at least two cycles. The WRITE comes 3 cycles after acceptance, or 4 with cfg_gap set.
- R7: A READ whose data cycle is two cycles after a cycle with dqm_out high produces no rd_valid beat. READs whose data precedes the mask still return normally.
- R8: With cfg_gap set to 1, rd_valid is 0 in the cycle just before any WRITE.
- R9: While a turnaround is pending, req_ready is 0 and cmd_code is NOP.
- R10: dq_oe is never high in a cycle in which rd_valid is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_cas3 | input | 1 | 1: CAS latency 3, 0: CAS latency 2 (held static while traffic flows) |
| cfg_gap | input | 1 | 1: at least one idle bus cycle between the last read word and a WRITE |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1: write request, 0: read request |
| req_bank | input | BANK_W | Target bank |
| req_col | input | COL_W | Target column |
| req_tag | input | TAG_W | Read tag returned with the data |
| req_wdata | input | DATA_W | Write word |
| cmd_code | output | 2 | 00 NOP, 01 READ, 10 WRITE |
| cmd_bank | output | BANK_W | Bank field of the command |
| cmd_col | output | COL_W | Column field of the command |
| dqm_out | output | 1 | Data mask to the memory |
| dq_oe | output | 1 | Controller data-driver enable |
| dq_wdata | output | DATA_W | Word driven on the data bus when dq_oe is high |
| dq_rdata | input | DATA_W | Data bus as seen by the controller |
| rd_valid | output | 1 | Returned read word valid |
| rd_tag | output | TAG_W | Tag of the returned word |
| rd_data | output | DATA_W | Returned read word |

## Verification
Suppose the outstanding-read counter is stale or the slot choice is wrong. Then the WRITE lands either on a cycle that still carries unmasked read data, where dq_oe and rd_valid rise together at once, or one cycle later than required, which shows as an extra NOP with req_ready low. A wrong mask history is different: a beat is dropped or delivered within two cycles of the DQM change, so the tag sequence on rd_tag shows the error at the data cycle. Directed cases cover both CAS latencies, with and without the idle gap, in the draining, truncating and idle situations.

// File: rtl/sdram_rtw_pkg.sv
package sdram_rtw_pkg;
    typedef enum logic [1:0] {
        CMD_NOP   = 2'b00,
        CMD_READ  = 2'b01,
        CMD_WRITE = 2'b10
    } cmd_e;

    // supported CAS latencies
    localparam int CL_LO = 2;
    localparam int CL_HI = 3;
    localparam int MAX_CL = CL_HI;
    // cycles between DQM and the read word it suppresses
    localparam int DQM_LEAD = 2;
    // counter width able to hold MAX_CL + 1 + gap
    localparam int LEFT_W = $clog2(MAX_CL + 3);
endpackage

// File: rtl/sdram_rtw_issue.sv
module sdram_rtw_issue
    import sdram_rtw_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cas3,
    input  logic              cfg_gap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [1:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic [TAG_W-1:0]  cmd_tag,
    output logic              dqm_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_wdata
);
    typedef struct packed {
        cmd_e              cmd;
        logic [BANK_W-1:0] bank;
        logic [COL_W-1:0]  col;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] wdata;
        logic              oe;
        logic              dqm;
        logic [LEFT_W-1:0] wait_cnt;  // cycles until the pending WRITE
        logic              trunc;     // pending WRITE truncates reads
        logic [LEFT_W-1:0] rd_left;   // cycles until read data has drained
    } issue_st_t;

    issue_st_t st_q, st_d;

    logic [LEFT_W-1:0] rd_span;
    logic [LEFT_W-1:0] slot_drain_d;
    logic [LEFT_W-1:0] slot_trunc_d;
    logic [LEFT_W-1:0] slot_d;
    logic              use_trunc_d;

    always_comb begin
        // a READ shown next cycle keeps the bus busy for CL+1 cycles from then
        rd_span = cfg_cas3 ? LEFT_W'(CL_HI + 1) : LEFT_W'(CL_LO + 1);

        // slot after the last read word (plus the optional idle cycle)
        if (st_q.rd_left == '0) begin
            slot_drain_d = LEFT_W'(1);
        end else begin
            slot_drain_d = st_q.rd_left + LEFT_W'(cfg_gap);
        end
        // earliest slot that leaves room for DQM lead cycles
        slot_trunc_d = LEFT_W'(DQM_LEAD + 1) + LEFT_W'(cfg_gap);
        use_trunc_d  = (slot_trunc_d < slot_drain_d);
        slot_d       = use_trunc_d ? slot_trunc_d : slot_drain_d;

        st_d     = st_q;
        st_d.cmd = CMD_NOP;
        st_d.oe  = 1'b0;
        st_d.dqm = 1'b0;
        st_d.rd_left = (st_q.rd_left != '0) ? st_q.rd_left - LEFT_W'(1) : '0;

        if (st_q.wait_cnt != '0) begin
            if (st_q.wait_cnt == LEFT_W'(1)) begin
                st_d.cmd      = CMD_WRITE;
                st_d.oe       = 1'b1;
                st_d.wait_cnt = '0;
                st_d.trunc    = 1'b0;
            end else begin
                st_d.wait_cnt = st_q.wait_cnt - LEFT_W'(1);
                st_d.dqm      = st_q.trunc;
            end
        end else if (req_valid) begin
            st_d.bank = req_bank;
            st_d.col  = req_col;
            if (!req_write) begin
                st_d.cmd     = CMD_READ;
                st_d.tag     = req_tag;
                st_d.rd_left = rd_span;
            end else begin
                st_d.wdata = req_wdata;
                if (slot_d == LEFT_W'(1)) begin
                    st_d.cmd = CMD_WRITE;
                    st_d.oe  = 1'b1;
                end else begin
                    st_d.wait_cnt = slot_d - LEFT_W'(1);
                    st_d.trunc    = use_trunc_d;
                    st_d.dqm      = use_trunc_d;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cmd: CMD_NOP, default: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign req_ready = (st_q.wait_cnt == '0);
    assign cmd_code  = st_q.cmd;
    assign cmd_bank  = st_q.bank;
    assign cmd_col   = st_q.col;
    assign cmd_tag   = st_q.tag;
    assign dqm_out   = st_q.dqm;
    assign dq_oe     = st_q.oe;
    assign dq_wdata  = st_q.wdata;
endmodule

// File: rtl/sdram_rtw_return.sv
module sdram_rtw_return
    import sdram_rtw_pkg::*;
#(
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cas3,
    input  logic              iss_read,
    input  logic [TAG_W-1:0]  iss_tag,
    input  logic              dqm_bus,
    input  logic [DATA_W-1:0] dq_rdata,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    typedef struct packed {
        logic [MAX_CL:1]             vld;    // READ age k cycles ago
        logic [MAX_CL:1][TAG_W-1:0]  tag;
        logic [DQM_LEAD:1]           mask;   // DQM age k cycles ago
    } ret_st_t;

    ret_st_t st_q, st_d;

    always_comb begin
        st_d        = st_q;
        st_d.vld[1] = iss_read;
        st_d.tag[1] = iss_tag;
        for (int k = 2; k <= MAX_CL; k++) begin
            st_d.vld[k] = st_q.vld[k-1];
            st_d.tag[k] = st_q.tag[k-1];
        end
        st_d.mask[1] = dqm_bus;
        for (int k = 2; k <= DQM_LEAD; k++) begin
            st_d.mask[k] = st_q.mask[k-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    logic             due_vld;
    logic [TAG_W-1:0] due_tag;

    always_comb begin
        if (cfg_cas3) begin
            due_vld = st_q.vld[CL_HI];
            due_tag = st_q.tag[CL_HI];
        end else begin
            due_vld = st_q.vld[CL_LO];
            due_tag = st_q.tag[CL_LO];
        end
    end

    assign rd_valid = due_vld & ~st_q.mask[DQM_LEAD];
    assign rd_tag   = due_tag;
    assign rd_data  = dq_rdata;
endmodule

// File: rtl/sdram_rtw_sched.sv
module sdram_rtw_sched
    import sdram_rtw_pkg::*;
#(
    parameter int BANK_W = 2,
    parameter int COL_W  = 9,
    parameter int TAG_W  = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_cas3,
    input  logic              cfg_gap,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_col,
    input  logic [TAG_W-1:0]  req_tag,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [1:0]        cmd_code,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [COL_W-1:0]  cmd_col,
    output logic              dqm_out,
    output logic              dq_oe,
    output logic [DATA_W-1:0] dq_wdata,
    input  logic [DATA_W-1:0] dq_rdata,
    output logic              rd_valid,
    output logic [TAG_W-1:0]  rd_tag,
    output logic [DATA_W-1:0] rd_data
);
    logic [TAG_W-1:0] cmd_tag;
    logic             iss_read;

    sdram_rtw_issue #(
        .BANK_W(BANK_W), .COL_W(COL_W), .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_issue (
        .clk(clk), .rst_n(rst_n),
        .cfg_cas3(cfg_cas3), .cfg_gap(cfg_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_col(req_col), .req_tag(req_tag),
        .req_wdata(req_wdata),
        .cmd_code(cmd_code), .cmd_bank(cmd_bank), .cmd_col(cmd_col),
        .cmd_tag(cmd_tag), .dqm_out(dqm_out), .dq_oe(dq_oe),
        .dq_wdata(dq_wdata)
    );

    assign iss_read = (cmd_code == CMD_READ);

    sdram_rtw_return #(
        .TAG_W(TAG_W), .DATA_W(DATA_W)
    ) u_return (
        .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3),
        .iss_read(iss_read), .iss_tag(cmd_tag), .dqm_bus(dqm_out),
        .dq_rdata(dq_rdata),
        .rd_valid(rd_valid), .rd_tag(rd_tag), .rd_data(rd_data)
    );
endmodule

// File: rtl/sdram_rtw_chk.sv
module sdram_rtw_chk
    import sdram_rtw_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_gap,
    input logic       req_valid,
    input logic       req_ready,
    input logic       req_write,
    input logic [1:0] cmd_code,
    input logic       dqm_out,
    input logic       dq_oe,
    input logic       rd_valid
);
    // R2
    read_issue_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> (cmd_code == CMD_READ));

    // R4
    oe_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe == (cmd_code == CMD_WRITE));

    // R9
    stall_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> (cmd_code == CMD_NOP));

    // R6
    dqm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dqm_out |=> (dqm_out || cmd_code == CMD_WRITE));

    // R6
    dqm_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dqm_out) |=> dqm_out);

    // R10
    oe_clash_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dq_oe |-> !rd_valid);

    // R8
    gap_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_gap && dq_oe) |-> !$past(rd_valid));
endmodule

bind sdram_rtw_sched sdram_rtw_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_gap(cfg_gap),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .cmd_code(cmd_code), .dqm_out(dqm_out), .dq_oe(dq_oe),
    .rd_valid(rd_valid)
);

// File: tb/sdram_rtw_sched_test.sv
module sdram_rtw_sched_test;
    localparam int BW = 2, CW = 9, TW = 4, DW = 16;
    localparam int LOGN = 2048;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_cas3 = 1'b0, cfg_gap = 1'b0;
    logic          req_valid = 1'b0, req_write = 1'b0;
    logic          req_ready;
    logic [BW-1:0] req_bank = '0;
    logic [CW-1:0] req_col = '0;
    logic [TW-1:0] req_tag = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [1:0]    cmd_code;
    logic [BW-1:0] cmd_bank;
    logic [CW-1:0] cmd_col;
    logic          dqm_out, dq_oe, rd_valid;
    logic [DW-1:0] dq_wdata, dq_rdata, rd_data;
    logic [TW-1:0] rd_tag;

    int cyc = 0;
    int n_chk = 0, n_fail = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;
    assign dq_rdata = cyc[15:0] ^ 16'h5A5A;

    sdram_rtw_sched uut (
        .clk(clk), .rst_n(rst_n), .cfg_cas3(cfg_cas3), .cfg_gap(cfg_gap),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_bank(req_bank), .req_col(req_col), .req_tag(req_tag),
        .req_wdata(req_wdata), .cmd_code(cmd_code), .cmd_bank(cmd_bank),
        .cmd_col(cmd_col), .dqm_out(dqm_out), .dq_oe(dq_oe),
        .dq_wdata(dq_wdata), .dq_rdata(dq_rdata), .rd_valid(rd_valid),
        .rd_tag(rd_tag), .rd_data(rd_data)
    );

    // per-cycle record of the outputs, sampled mid-cycle
    int cmd_l [LOGN], bank_l [LOGN], col_l [LOGN], dqm_l [LOGN], oe_l [LOGN];
    int wd_l [LOGN], rv_l [LOGN], rt_l [LOGN], rd_l [LOGN], rdy_l [LOGN];

    always @(negedge clk) begin
        if (cyc < LOGN) begin
            cmd_l[cyc] = int'(cmd_code);
            bank_l[cyc] = int'(cmd_bank);
            col_l[cyc] = int'(cmd_col);
            dqm_l[cyc] = int'(dqm_out);
            oe_l[cyc] = int'(dq_oe);
            wd_l[cyc] = int'(dq_wdata);
            rv_l[cyc] = int'(rd_valid);
            rt_l[cyc] = int'(rd_tag);
            rd_l[cyc] = int'(rd_data);
            rdy_l[cyc] = int'(req_ready);
        end
    end

    task automatic chk(input string rq, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    task automatic push(input bit wr, input int bank, input int col, input int tag,
                        input int wd, output int acc);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_bank  = BW'(bank);
        req_col   = CW'(col);
        req_tag   = TW'(tag);
        req_wdata = DW'(wd);
        while (!req_ready) @(negedge clk);
        acc = cyc;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic set_cfg(input bit cas3, input bit gap);
        @(negedge clk);
        cfg_cas3 = cas3;
        cfg_gap  = gap;
        idle(6);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R1", "cmd in reset", int'(cmd_code), 0);
        chk("R1", "dqm in reset", int'(dqm_out), 0);
        chk("R1", "oe in reset", int'(dq_oe), 0);
        chk("R1", "rd_valid in reset", int'(rd_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "ready after reset", int'(req_ready), 1);
        chk("R1", "cmd after reset", int'(cmd_code), 0);
    endtask

    // back-to-back reads; returns at READ cycle + CL
    task automatic t_reads(input bit cas3, input int n);
        int acc [8];
        int cl;
        cl = cas3 ? 3 : 2;
        set_cfg(cas3, 1'b0);
        for (int i = 0; i < n; i++) push(1'b0, i, 16 + i, 1 + i, 0, acc[i]);
        idle(8);
        for (int i = 0; i < n; i++) begin
            chk("R2", "read accept spacing", acc[i] - acc[0], i);
            chk("R2", "READ code", cmd_l[acc[i]+1], 1);
            chk("R2", "READ bank", bank_l[acc[i]+1], i);
            chk("R2", "READ col", col_l[acc[i]+1], 16 + i);
            chk("R3", "beat valid", rv_l[acc[i]+1+cl], 1);
            chk("R3", "beat tag", rt_l[acc[i]+1+cl], 1 + i);
            chk("R3", "beat data", rd_l[acc[i]+1+cl], (acc[i]+1+cl) ^ 'h5A5A);
            chk("R3", "no early beat", rv_l[acc[0]+cl], 0);
        end
        chk("R3", "no beat after stream", rv_l[acc[n-1]+2+cl], 0);
    endtask

    // write from idle, then a read right after it
    task automatic t_idle_write();
        int a, r;
        set_cfg(1'b0, 1'b0);
        push(1'b1, 2, 33, 0, 'hBEEF, a);
        push(1'b0, 1, 7, 9, 0, r);
        idle(8);
        chk("R4", "WRITE next cycle", cmd_l[a+1], 2);
        chk("R4", "WRITE bank", bank_l[a+1], 2);
        chk("R4", "WRITE col", col_l[a+1], 33);
        chk("R4", "oe with WRITE", oe_l[a+1], 1);
        chk("R4", "wdata", wd_l[a+1], 'hBEEF);
        chk("R4", "oe before WRITE", oe_l[a], 0);
        chk("R4", "oe after WRITE", oe_l[a+2], 0);
        chk("R5", "no mask from idle", dqm_l[a+1], 0);
        chk("R2", "read after write", cmd_l[r+1], 1);
        chk("R3", "read after write returns", rt_l[r+3], 9);
    endtask

    // one read then write: waits for the data to drain
    task automatic t_drain(input bit gap);
        int r, a, w;
        set_cfg(1'b0, gap);
        push(1'b0, 3, 5, 6, 0, r);
        push(1'b1, 0, 40, 0, 'h1234, a);
        idle(8);
        w = a + 3 + (gap ? 1 : 0);
        chk("R5", "write accept", a - r, 1);
        chk("R9", "ready low in wait", rdy_l[a+1], 0);
        chk("R9", "NOP in wait", cmd_l[a+1], 0);
        chk("R5", "NOP before WRITE", cmd_l[w-1], 0);
        chk("R5", "WRITE slot", cmd_l[w], 2);
        chk("R5", "wdata", wd_l[w], 'h1234);
        for (int k = a + 1; k <= w; k++) chk("R5", "no dqm", dqm_l[k], 0);
        chk("R3", "beat kept", rv_l[r+3], 1);
        chk("R3", "beat tag", rt_l[r+3], 6);
        chk("R10", "no data at WRITE", rv_l[w], 0);
        if (gap) chk("R8", "idle before WRITE", rv_l[w-1], 0);
    endtask

    // two reads then write with CL 3: truncation
    task automatic t_trunc(input bit gap);
        int r0, r1, a, w;
        set_cfg(1'b1, gap);
        push(1'b0, 1, 11, 3, 0, r0);
        push(1'b0, 2, 12, 4, 0, r1);
        push(1'b1, 3, 50, 0, 'hCAFE, a);
        idle(8);
        w = a + 3 + (gap ? 1 : 0);
        chk("R6", "write accept", a - r1, 1);
        chk("R6", "dqm low at accept", dqm_l[a], 0);
        for (int k = a + 1; k < w; k++) chk("R6", "dqm lead", dqm_l[k], 1);
        chk("R6", "dqm low at WRITE", dqm_l[w], 0);
        chk("R6", "WRITE slot", cmd_l[w], 2);
        chk("R6", "NOP before WRITE", cmd_l[w-1], 0);
        chk("R9", "ready low in wait", rdy_l[w-1], 0);
        chk("R7", "earlier beat kept", rv_l[a+2], 1);
        chk("R7", "earlier beat tag", rt_l[a+2], 3);
        chk("R7", "masked beat dropped", rv_l[a+3], 0);
        chk("R10", "no data at WRITE", rv_l[w], 0);
        chk("R10", "oe at WRITE", oe_l[w], 1);
        if (gap) chk("R8", "idle before WRITE", rv_l[w-1], 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_reads(1'b0, 4);
        t_reads(1'b1, 3);
        t_idle_write();
        t_drain(1'b0);
        t_drain(1'b1);
        t_trunc(1'b0);
        t_trunc(1'b1);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule